// File: doc/BRIEF.md
# Codec Register Command Sequencer

This block programs the control registers of an audio codec across the command slots of the serial output frame. It stays silent until the codec reports that it is ready. It then writes a fixed set of eight registers in a fixed order. These are four output volume registers, the record source selector, the record gain, and the two converter sample-rate registers. After that it follows two switch-driven settings, one for the speaker and one for the microphone. Whenever either setting changes, it writes again every register that depends on it.

Each setting is six bits wide: a mute flag in bit 5 and a 5-bit level in bits 4:0, where a larger level means louder. The four output volume registers count attenuation, so a larger field value is quieter. They take the speaker setting, inverted, in 5-bit left and right fields. The record gain register counts gain in 4-bit fields and takes the microphone level with its least significant bit dropped. The block presents at most one write per frame. A one-cycle frame strobe from the frame serializer marks where each frame starts. The address and data are held on the outputs until the next strobe, and `cmd_valid` low marks the slots of that frame as carrying no command.

The control path has three states. `ST_WAIT_READY` is entered from reset and moves to `ST_INIT` on `codec_ready`. `ST_INIT` moves to `ST_TRACK` once the eighth register (index 7) has been written. `ST_TRACK` is terminal. Pending writes sit in one dirty flag per register. Entering `ST_INIT` sets all eight flags. A setting change sets the flags of the registers that depend on it. A round-robin picker chooses the next flag at or after the position that follows the last write.

Top module: `codec_cmd_seq`

## Requirements
- R1: While the codec has not yet reported ready, `cmd_valid` stays 0, and it is 0 after reset.
- R2: The command outputs change only on the clock edge at which `frame_strobe` is high; between strobes `cmd_valid`, `cmd_addr` and `cmd_data` hold their values.
- R3: After ready, the first eight strobes carry writes to addresses 0x02, 0x04, 0x10, 0x18, 0x1A, 0x1C, 0x2C, 0x32, in that order, when the settings do not change meanwhile.
- R4: A write to 0x02, 0x04, 0x10 or 0x18 carries the speaker mute in bit 15, carries 31 minus the speaker level in bits 12:8 and in bits 4:0, and has all other bits 0.
- R5: A write to 0x1C carries the microphone mute in bit 15, carries microphone level bits 4:1 in bits 11:8 and in bits 3:0, and has all other bits 0.
- R6: A write to 0x1A carries the parameter `REC_SOURCE` (default 0x0000); writes to 0x2C and 0x32 carry the parameter `SAMPLE_RATE` (default 0x1F40).
- R7: When no register is pending, a strobe drives `cmd_valid` to 0.
- R8: A speaker change causes writes to exactly 0x02, 0x04, 0x10, 0x18; a microphone change causes a write to exactly 0x1C. The writes go in round-robin index order, starting at the position after the last write.
- R9: No write ever addresses 0x0E or any address outside the eight listed.
- R10: The data of every write is encoded from the settings present at its strobe. Once the settings are stable, the last value written to each register equals the encoding of the current settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_ready | input | 1 | Codec reports ready (sampled level) |
| frame_strobe | input | 1 | One-cycle pulse at each output frame start |
| spk_setting | input | 6 | Speaker setting: bit 5 mute, bits 4:0 level |
| mic_setting | input | 6 | Microphone setting: bit 5 mute, bits 4:0 level |
| cmd_valid | output | 1 | Command slots of the current frame carry a write |
| cmd_addr | output | 8 | Register index for the slot-1 word |
| cmd_data | output | 16 | Register data for the slot-2 word |

## Verification
The assertions check the following on every cycle:
- silence before ready;
- outputs that hold between strobes;
- the legal address set, with 0x0E excluded;
- the zero bits and the matched left and right fields of both volume formats;
- a mute bit that follows the setting sampled at the strobe.

The bench scenarios are needed for the behaviour that depends on order and history:
- the exact initialization order;
- which registers a change causes to be written again, and in what round-robin order;
- the polarity and bit-dropping at the extreme levels;
- the settled match between the last written values and a random stream of setting changes.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    localparam int NUM_REGS   = 8;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int CMD_ADDR_W = 8;
    localparam int CMD_DATA_W = 16;
    localparam int MUTE_BIT   = 15;
    localparam int LEFT_LSB   = 8;

    typedef enum logic [1:0] {
        ST_WAIT_READY,
        ST_INIT,
        ST_TRACK
    } seq_state_t;

    typedef enum logic [1:0] {
        ENC_ATTEN,
        ENC_GAIN,
        ENC_SOURCE,
        ENC_RATE
    } enc_kind_t;

    // Round-robin position -> register index (the order is the init order)
    function automatic logic [CMD_ADDR_W-1:0] reg_addr(input int idx);
        case (idx)
            0:       return 8'h02;
            1:       return 8'h04;
            2:       return 8'h10;
            3:       return 8'h18;
            4:       return 8'h1A;
            5:       return 8'h1C;
            6:       return 8'h2C;
            default: return 8'h32;
        endcase
    endfunction

    function automatic enc_kind_t reg_kind(input int idx);
        if (idx < 4)       return ENC_ATTEN;
        else if (idx == 4) return ENC_SOURCE;
        else if (idx == 5) return ENC_GAIN;
        else               return ENC_RATE;
    endfunction

    function automatic logic uses_spk(input int idx);
        return reg_kind(idx) == ENC_ATTEN;
    endfunction

    function automatic logic uses_mic(input int idx);
        return reg_kind(idx) == ENC_GAIN;
    endfunction

endpackage

// File: rtl/reg_word_enc.sv
module reg_word_enc
    import codec_seq_pkg::*;
#(
    parameter int                    IDX         = 0,
    parameter int                    LVL_W       = 5,
    parameter int                    GAIN_W      = 4,
    parameter logic [CMD_DATA_W-1:0] REC_SOURCE  = 16'h0000,
    parameter logic [CMD_DATA_W-1:0] SAMPLE_RATE = 16'h1F40
) (
    input  logic [LVL_W:0]          setting,
    output logic [CMD_DATA_W-1:0]   word
);
    localparam enc_kind_t KIND = reg_kind(IDX);

    generate
        if (KIND == ENC_ATTEN) begin : g_atten
            logic [LVL_W-1:0] atten;
            assign atten = ~setting[LVL_W-1:0];
            always_comb begin
                word                       = '0;
                word[MUTE_BIT]             = setting[LVL_W];
                word[LEFT_LSB +: LVL_W]    = atten;
                word[0 +: LVL_W]           = atten;
            end
        end else if (KIND == ENC_GAIN) begin : g_gain
            logic [GAIN_W-1:0]      gain;
            logic [LVL_W-GAIN_W-1:0] unused_bits;
            assign gain        = setting[LVL_W-1 -: GAIN_W];
            assign unused_bits = setting[LVL_W-GAIN_W-1:0];
            always_comb begin
                word                       = '0;
                word[MUTE_BIT]             = setting[LVL_W];
                word[LEFT_LSB +: GAIN_W]   = gain;
                word[0 +: GAIN_W]          = gain;
            end
        end else begin : g_fixed
            logic unused_bits;
            assign unused_bits = ^setting;
            assign word = (KIND == ENC_SOURCE) ? REC_SOURCE : SAMPLE_RATE;
        end
    endgenerate

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] sel
);
    always_comb begin
        int j;
        found = 1'b0;
        sel   = start;
        // scan downward so the nearest request after start wins
        for (int k = N - 1; k >= 0; k--) begin
            j = (int'(start) + k) % N;
            if (req[j]) begin
                found = 1'b1;
                sel   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
    import codec_seq_pkg::*;
#(
    parameter int                    LVL_W       = 5,
    parameter int                    GAIN_W      = 4,
    parameter logic [CMD_DATA_W-1:0] REC_SOURCE  = 16'h0000,
    parameter logic [CMD_DATA_W-1:0] SAMPLE_RATE = 16'h1F40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  codec_ready,
    input  logic                  frame_strobe,
    input  logic [LVL_W:0]        spk_setting,
    input  logic [LVL_W:0]        mic_setting,
    output logic                  cmd_valid,
    output logic [CMD_ADDR_W-1:0] cmd_addr,
    output logic [CMD_DATA_W-1:0] cmd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    seq_state_t state, state_n;

    logic [LVL_W:0]          spk_q, mic_q;
    logic                    spk_chg, mic_chg;
    logic [NUM_REGS-1:0]     dirty, dirty_n, mark;
    logic [IDX_W-1:0]        ptr, sel;
    logic                    found, issue;
    logic [CMD_ADDR_W-1:0]   addr_tab [NUM_REGS];
    logic [CMD_DATA_W-1:0]   word_tab [NUM_REGS];

    assign spk_chg = spk_setting != spk_q;
    assign mic_chg = mic_setting != mic_q;

    // One encoder per register; each picks the setting it depends on
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            assign addr_tab[i] = reg_addr(i);
            assign mark[i]     = (uses_spk(i) && spk_chg) || (uses_mic(i) && mic_chg);
            reg_word_enc #(
                .IDX(i), .LVL_W(LVL_W), .GAIN_W(GAIN_W),
                .REC_SOURCE(REC_SOURCE), .SAMPLE_RATE(SAMPLE_RATE)
            ) u_enc (
                .setting (uses_mic(i) ? mic_setting : spk_setting),
                .word    (word_tab[i])
            );
        end
    endgenerate

    rr_pick #(.N(NUM_REGS), .IDX_W(IDX_W)) u_pick (
        .req   (dirty),
        .start (ptr),
        .found (found),
        .sel   (sel)
    );

    assign issue = frame_strobe && (state != ST_WAIT_READY) && found;

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_WAIT_READY: if (codec_ready)               state_n = ST_INIT;
            ST_INIT:       if (issue && sel == LAST_IDX)  state_n = ST_TRACK;
            ST_TRACK:                                     state_n = ST_TRACK;
            default:                                      state_n = ST_WAIT_READY;
        endcase
    end

    // Pending-write flags: a new change wins over the clear of a write
    always_comb begin
        dirty_n = dirty;
        if (issue)
            dirty_n[sel] = 1'b0;
        dirty_n = dirty_n | mark;
        if (state == ST_WAIT_READY && codec_ready)
            dirty_n = '1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_READY;
        else        state <= state_n;
    end

    // Tracking registers and command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_q     <= '0;
            mic_q     <= '0;
            dirty     <= '0;
            ptr       <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            spk_q <= spk_setting;
            mic_q <= mic_setting;
            dirty <= dirty_n;
            if (frame_strobe) begin
                if (issue) begin
                    cmd_valid <= 1'b1;
                    cmd_addr  <= addr_tab[sel];
                    cmd_data  <= word_tab[sel];
                    ptr       <= (sel == LAST_IDX) ? '0 : sel + 1'b1;
                end else begin
                    cmd_valid <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/codec_cmd_seq_chk.sv
module codec_cmd_seq_chk #(
    parameter int LVL_W  = 5,
    parameter int GAIN_W = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          codec_ready,
    input logic          frame_strobe,
    input logic [LVL_W:0] spk_setting,
    input logic [LVL_W:0] mic_setting,
    input logic          cmd_valid,
    input logic [7:0]    cmd_addr,
    input logic [15:0]   cmd_data
);
    localparam logic [15:0] ATT_MASK  = 16'h8000 | 16'(((1 << LVL_W) - 1) << 8) | 16'((1 << LVL_W) - 1);
    localparam logic [15:0] GAIN_MASK = 16'h8000 | 16'(((1 << GAIN_W) - 1) << 8) | 16'((1 << GAIN_W) - 1);

    logic ready_seen;
    logic is_att;
    always_ff @(posedge clk) begin
        if (!rst_n) ready_seen <= 1'b0;
        else        ready_seen <= ready_seen | codec_ready;
    end

    assign is_att = cmd_addr inside {8'h02, 8'h04, 8'h10, 8'h18};

    // R1
    a_r1_silent_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_seen |-> !cmd_valid);

    // R2
    a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_strobe) |-> ($stable(cmd_valid) && $stable(cmd_addr) && $stable(cmd_data)));

    // R9
    a_r9_legal_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr inside {8'h02, 8'h04, 8'h10, 8'h18, 8'h1A, 8'h1C, 8'h2C, 8'h32}));

    // R4
    a_r4_atten_format: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_att) |-> (((cmd_data & ~ATT_MASK) == 16'h0) &&
                                   (cmd_data[8 +: LVL_W] == cmd_data[0 +: LVL_W])));

    // R4
    a_r4_master_mute: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_valid) && cmd_addr == 8'h02) |-> cmd_data[15] == $past(spk_setting[LVL_W]));

    // R5
    a_r5_gain_format: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_addr == 8'h1C) |-> (((cmd_data & ~GAIN_MASK) == 16'h0) &&
                                              (cmd_data[8 +: GAIN_W] == cmd_data[0 +: GAIN_W])));

    // R5
    a_r5_gain_mute: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_strobe) && cmd_valid && cmd_addr == 8'h1C) |-> cmd_data[15] == $past(mic_setting[LVL_W]));

endmodule

bind codec_cmd_seq codec_cmd_seq_chk #(.LVL_W(LVL_W), .GAIN_W(GAIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .codec_ready  (codec_ready),
    .frame_strobe (frame_strobe),
    .spk_setting  (spk_setting),
    .mic_setting  (mic_setting),
    .cmd_valid    (cmd_valid),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data)
);

// File: tb/tb_codec_cmd_seq.sv
module tb_codec_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        codec_ready = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [5:0]  spk_setting = '0;
    logic [5:0]  mic_setting = '0;
    logic        cmd_valid;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] last_w [32];

    always #2 clk = ~clk;

    codec_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .codec_ready(codec_ready),
        .frame_strobe(frame_strobe), .spk_setting(spk_setting),
        .mic_setting(mic_setting), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    function automatic logic [15:0] enc(input logic [7:0] a, input logic [5:0] spk, input logic [5:0] mic);
        logic [15:0] w;
        w = 16'h0;
        case (a)
            8'h02, 8'h04, 8'h10, 8'h18: begin
                w[15]   = spk[5];
                w[12:8] = 5'd31 - spk[4:0];
                w[4:0]  = 5'd31 - spk[4:0];
            end
            8'h1C: begin
                w[15]   = mic[5];
                w[11:8] = mic[4:1];
                w[3:0]  = mic[4:1];
            end
            8'h1A:        w = 16'h0000;
            8'h2C, 8'h32: w = 16'h1F40;
            default:      w = 16'hDEAD;
        endcase
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [7:0] a);
        strobe();
        chk(cmd_valid === 1'b1, req, "valid", {31'b0, cmd_valid}, 1);
        chk(cmd_addr === a, req, "addr", cmd_addr, a);
        chk(cmd_data === enc(a, spk_setting, mic_setting), req, "data",
            cmd_data, enc(a, spk_setting, mic_setting));
    endtask

    task automatic expect_idle(input string req);
        strobe();
        chk(cmd_valid === 1'b0, req, "idle valid", {31'b0, cmd_valid}, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] init_order [8];
        init_order = '{8'h02, 8'h04, 8'h10, 8'h18, 8'h1A, 8'h1C, 8'h2C, 8'h32};
        void'($urandom(32'd2007));

        repeat (5) @(negedge clk);
        chk(cmd_valid === 1'b0, "R1", "reset valid", {31'b0, cmd_valid}, 0);
        rst_n = 1'b1;

        // R1: strobes before ready produce nothing
        for (int i = 0; i < 3; i++) begin
            expect_idle("R1");
        end

        spk_setting = 6'b0_10110;
        mic_setting = 6'b0_01101;
        repeat (2) @(negedge clk);
        codec_ready = 1'b1;
        repeat (2) @(negedge clk);

        // R3, R4, R5, R6: initialization sweep
        for (int i = 0; i < 8; i++) begin
            expect_write("R3", init_order[i]);
        end
        expect_idle("R7");
        expect_idle("R7");

        // R8 + R4 boundary: muted, level 0 -> full attenuation
        spk_setting = 6'b1_00000;
        expect_write("R8", 8'h02);
        begin
            logic [15:0] held;
            held = cmd_data;
            repeat (5) @(negedge clk);
            chk(cmd_valid === 1'b1 && cmd_addr === 8'h02 && cmd_data === held,
                "R2", "held outputs", cmd_data, held);
        end
        chk(cmd_data === 16'h9F1F, "R4", "mute+atten31", cmd_data, 16'h9F1F);
        expect_write("R8", 8'h04);
        expect_write("R8", 8'h10);
        expect_write("R8", 8'h18);
        expect_idle("R8");

        // R5 boundary: top mic level -> gain 15, lsb dropped
        mic_setting = 6'b0_11111;
        expect_write("R5", 8'h1C);
        chk(cmd_data === 16'h0F0F, "R5", "gain15", cmd_data, 16'h0F0F);
        expect_idle("R8");

        // both change: speaker level 31 -> zero attenuation
        spk_setting = 6'b0_11111;
        mic_setting = 6'b1_00001;
        expect_write("R8", 8'h02);
        chk(cmd_data === 16'h0000, "R4", "atten0", cmd_data, 16'h0000);
        expect_write("R8", 8'h04);
        expect_write("R8", 8'h10);
        expect_write("R8", 8'h18);
        expect_write("R5", 8'h1C);
        chk(cmd_data === 16'h8000, "R5", "mute gain0", cmd_data, 16'h8000);
        expect_idle("R7");

        for (int i = 0; i < 32; i++) last_w[i] = 16'hxxxx;

        // R10, R9: random setting changes between strobes
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 3) == 0) spk_setting = 6'($urandom);
            if ($urandom_range(0, 4) == 0) mic_setting = 6'($urandom);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            strobe();
            if (cmd_valid === 1'b1) begin
                chk(cmd_addr inside {8'h02, 8'h04, 8'h10, 8'h18, 8'h1A, 8'h1C, 8'h2C, 8'h32},
                    "R9", "legal addr", cmd_addr, 8'h02);
                chk(cmd_data === enc(cmd_addr, spk_setting, mic_setting), "R10", "rand data",
                    cmd_data, enc(cmd_addr, spk_setting, mic_setting));
                last_w[cmd_addr[5:1]] = cmd_data;
            end
        end
        for (int i = 0; i < 8; i++) begin
            strobe();
            if (cmd_valid === 1'b1) last_w[cmd_addr[5:1]] = cmd_data;
        end
        for (int i = 0; i < 6; i++) begin
            if (i != 4) begin
                logic [7:0] a;
                a = init_order[i];
                chk(last_w[a[5:1]] === enc(a, spk_setting, mic_setting), "R10", "settled",
                    last_w[a[5:1]], enc(a, spk_setting, mic_setting));
            end
        end
        expect_idle("R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule